// File: doc/BRIEF.md
# Power-Up Strap Sampling Sequencer

This block decides, once per power-up, how a clock generator configures itself from board straps. Five dual-purpose pads carry a strap resistor each: four frequency-select bits and one mode bit. When the power-good input rises, the sequencer keeps all five pad drivers in high impedance. This lets the straps settle the pad levels. It counts a fixed number of timer ticks and, on the last tick, stores the synchronised level of every pad. One clock later it turns the output drivers on, so the pads become clock outputs.

The stored mode bit decides what a separate shared pin does. With mode 1, that pin drives a reference clock, so its driver is enabled. With mode 0, it stays an input that requests a stop of the PCI clocks, active low. The stored four-bit code is the hardware frequency choice. A software-select input can replace it with a software code. The stored values never change while power-good stays high. Only a power cycle arms a new sample.

Top module: `strap_sampler`

## Requirements
- R1: While `pwr_good` is low, `done`, `strap_oe`, `pin2_oe`, `fs_code` and `mode_bit` are all 0, and `pci_stop_n` is 1.
- R2: After `pwr_good` rises, the window lasts exactly `WIN_TICKS` clock cycles with `tick` high. Before the last of those ticks, `done` stays 0.
- R3: While `done` is 0, all five bits of `strap_oe` are 0, so the strap pads stay in high impedance.
- R4: On the clock edge that sees the last window tick, `fs_code[i]` takes the level of `strap_pad[i]` (i = 0..3) and `mode_bit` takes `strap_pad[4]`. The level used is the one the pad held two clock edges earlier, because of a two-flop synchroniser.
- R5: `done` and all five `strap_oe` bits rise together, one clock after the capture edge. They stay high while `pwr_good` stays high.
- R6: After capture, changes on the pads or on `tick` do not alter `fs_code`, `mode_bit` or `done`.
- R7: A low pulse on `pwr_good` clears the stored state. The next rise starts a new window, which samples the pads again.
- R8: `active_fs` equals `sw_fs` when `sw_sel` is 1, and equals `fs_code` when `sw_sel` is 0.
- R9: `pin2_oe` is 1 only when `done` is 1 and `mode_bit` is 1. When `done` is 1 and `mode_bit` is 0, `pci_stop_n` follows `pin2_pad` two clock edges later. Otherwise `pci_stop_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_good | input | 1 | Supply-good indication; low acts as the synchronous reset |
| tick | input | 1 | One-cycle timebase pulse that counts the sampling window |
| strap_pad | input | 5 | Pad levels: [3:0] frequency select, [4] mode |
| pin2_pad | input | 1 | Level on the shared stop-request / reference pin |
| sw_sel | input | 1 | 1 selects the software frequency code |
| sw_fs | input | 4 | Software frequency code |
| strap_oe | output | 5 | Output-driver enables for the five strap pads |
| pin2_oe | output | 1 | Driver enable for the shared pin (reference clock mode) |
| pci_stop_n | output | 1 | PCI clock stop request, active low |
| fs_code | output | 4 | Stored hardware frequency code |
| mode_bit | output | 1 | Stored mode strap |
| active_fs | output | 4 | Frequency code in effect |
| done | output | 1 | Sampling finished and drivers enabled |

## Verification
The risky overlap is a pad edge that falls in the same cycle as the last window tick. The bench changes every strap pad on the negative edge just before the terminal tick is sampled. The synchroniser means the stored code must still hold the old levels, and the bench judges the result that way. A second overlap arises when software and hardware selection meet. The bench toggles `sw_sel` across stored codes and expects `active_fs` to switch at once, while `fs_code` holds still.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int STRAP_PINS = 5;
    localparam int FS_BITS    = 4;

    typedef enum logic [1:0] {
        ST_WINDOW  = 2'd0,
        ST_LATCHED = 2'd1,
        ST_RUN     = 2'd2
    } strap_state_e;

    typedef struct packed {
        logic               mode;
        logic [FS_BITS-1:0] fs;
    } strap_cfg_t;

    function automatic strap_cfg_t unpack_pads(input logic [STRAP_PINS-1:0] p);
        strap_cfg_t c;
        c.fs   = p[FS_BITS-1:0];
        c.mode = p[FS_BITS];
        return c;
    endfunction

    function automatic logic [FS_BITS-1:0] pick_fs(input logic use_sw,
                                                   input logic [FS_BITS-1:0] sw,
                                                   input logic [FS_BITS-1:0] hw);
        return use_sw ? sw : hw;
    endfunction

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end
endmodule

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
    parameter int WIN_TICKS = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic expire
);
    localparam int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

    logic [CW-1:0] cnt;
    logic          armed;

    assign expire = armed && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            armed <= 1'b1;
        end else if (armed && tick) begin
            if (cnt == LAST) begin
                armed <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  expire,
    input  logic [STRAP_PINS-1:0] pads_sync,
    output strap_cfg_t            cfg,
    output logic                  done
);
    strap_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WINDOW;
            cfg   <= '0;
        end else begin
            case (state)
                ST_WINDOW: if (expire) begin
                    cfg   <= unpack_pads(pads_sync);
                    state <= ST_LATCHED;
                end
                ST_LATCHED: state <= ST_RUN;
                default:    state <= ST_RUN;
            endcase
        end
    end

    assign done = (state == ST_RUN);
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
    import strap_pkg::*;
#(
    parameter int WIN_TICKS = 2000
) (
    input  logic                  clk,
    input  logic                  pwr_good,
    input  logic                  tick,
    input  logic [STRAP_PINS-1:0] strap_pad,
    input  logic                  pin2_pad,
    input  logic                  sw_sel,
    input  logic [FS_BITS-1:0]    sw_fs,
    output logic [STRAP_PINS-1:0] strap_oe,
    output logic                  pin2_oe,
    output logic                  pci_stop_n,
    output logic [FS_BITS-1:0]    fs_code,
    output logic                  mode_bit,
    output logic [FS_BITS-1:0]    active_fs,
    output logic                  done
);
    localparam int SYNC_W = STRAP_PINS + 1;

    logic              rst;
    logic [SYNC_W-1:0] sync_q;
    logic              expire;
    strap_cfg_t        cfg;

    assign rst = ~pwr_good;

    strap_sync #(.WIDTH(SYNC_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({pin2_pad, strap_pad}),
        .q   (sync_q)
    );

    strap_window_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .expire (expire)
    );

    strap_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .expire    (expire),
        .pads_sync (sync_q[STRAP_PINS-1:0]),
        .cfg       (cfg),
        .done      (done)
    );

    assign strap_oe   = {STRAP_PINS{done}};
    assign fs_code    = cfg.fs;
    assign mode_bit   = cfg.mode;
    assign active_fs  = pick_fs(sw_sel, sw_fs, cfg.fs);
    assign pin2_oe    = done & cfg.mode;
    assign pci_stop_n = (done && !cfg.mode) ? sync_q[STRAP_PINS] : 1'b1;
endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk (
    input logic       clk,
    input logic       pwr_good,
    input logic [4:0] strap_oe,
    input logic       pin2_oe,
    input logic [3:0] fs_code,
    input logic       mode_bit,
    input logic       done
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !pwr_good |=> (!done && strap_oe == 5'd0));

    // R3
    oe_quiet_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        !done |-> (strap_oe == 5'd0));

    // R5
    done_sticky_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        done |=> done);

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        done |=> ($stable(fs_code) && $stable(mode_bit)));

    // R9
    pin2_drive_chk: assert property (@(posedge clk) disable iff (!pwr_good)
        pin2_oe |-> (done && mode_bit));
endmodule

bind strap_sampler strap_sampler_chk u_chk (
    .clk      (clk),
    .pwr_good (pwr_good),
    .strap_oe (strap_oe),
    .pin2_oe  (pin2_oe),
    .fs_code  (fs_code),
    .mode_bit (mode_bit),
    .done     (done)
);

// File: tb/strap_sampler_tb_top.sv
module strap_sampler_tb_top;
    localparam int W = 6;
    localparam int NV = 6;
    // {pads[4:0], sw_sel, sw_fs[3:0]}
    localparam logic [9:0] VEC [NV] = '{
        10'b01010_0_0000, 10'b10101_0_1111, 10'b11111_1_0011,
        10'b00000_1_1001, 10'b10110_0_0110, 10'b01001_1_1110
    };

    logic clk = 0, pwr_good = 0, tick = 0, pin2_pad = 0, sw_sel = 0;
    logic [4:0] strap_pad = 0;
    logic [3:0] sw_fs = 0;
    logic [4:0] strap_oe;
    logic pin2_oe, pci_stop_n, mode_bit, done;
    logic [3:0] fs_code, active_fs;
    int n_run = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    strap_sampler #(.WIN_TICKS(W)) dut_i (
        .clk(clk), .pwr_good(pwr_good), .tick(tick), .strap_pad(strap_pad),
        .pin2_pad(pin2_pad), .sw_sel(sw_sel), .sw_fs(sw_fs), .strap_oe(strap_oe),
        .pin2_oe(pin2_oe), .pci_stop_n(pci_stop_n), .fs_code(fs_code),
        .mode_bit(mode_bit), .active_fs(active_fs), .done(done)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic power_cycle(input logic [4:0] pads);
        @(negedge clk); pwr_good = 0; tick = 0; strap_pad = pads;
        repeat (3) @(negedge clk);
        pwr_good = 1;
    endtask

    // runs window; flip_pads at terminal tick if requested
    task automatic run_window(input logic flip);
        for (int i = 0; i < W; i++) begin
            @(negedge clk); tick = 1;
            if (flip && i == W-1) strap_pad = ~strap_pad;
            @(negedge clk); tick = 0;
            if (i == W-2) begin
                chk("R2 done low before last tick", {7'd0, done}, 8'd0);
                chk("R3 oe low in window", {3'd0, strap_oe}, 8'd0);
            end
        end
        chk("R5 done one cycle after capture", {7'd0, done}, 8'd0);
        @(negedge clk);
        chk("R5 done high", {7'd0, done}, 8'd1);
        chk("R5 oe high", {3'd0, strap_oe}, 8'h1f);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 done", {7'd0, done}, 8'd0);
        chk("R1 oe", {3'd0, strap_oe}, 8'd0);
        chk("R1 fs_code", {4'd0, fs_code}, 8'd0);
        chk("R1 pci_stop_n", {7'd0, pci_stop_n}, 8'd1);

        for (int v = 0; v < NV; v++) begin
            power_cycle(VEC[v][9:5]);
            sw_sel = VEC[v][4]; sw_fs = VEC[v][3:0];
            run_window(1'b0);
            chk("R4 fs_code", {4'd0, fs_code}, {4'd0, VEC[v][8:5]});
            chk("R4 mode_bit", {7'd0, mode_bit}, {7'd0, VEC[v][9]});
            chk("R8 active_fs", {4'd0, active_fs},
                {4'd0, VEC[v][4] ? VEC[v][3:0] : VEC[v][8:5]});
            chk("R9 pin2_oe", {7'd0, pin2_oe}, {7'd0, VEC[v][9]});
        end

        // R8 toggle sw_sel with stored code 1001 (last vector)
        sw_sel = 0; #1;
        chk("R8 hw select", {4'd0, active_fs}, 8'h09);
        sw_sel = 1; sw_fs = 4'h5; #1;
        chk("R8 sw select", {4'd0, active_fs}, 8'h05);
        chk("R8 fs_code unchanged", {4'd0, fs_code}, 8'h09);

        // R6 pad changes and ticks after done
        strap_pad = 5'b10110;
        repeat (3) begin @(negedge clk); tick = 1; @(negedge clk); tick = 0; end
        repeat (3) @(negedge clk);
        chk("R6 fs_code held", {4'd0, fs_code}, 8'h09);
        chk("R6 mode held", {7'd0, mode_bit}, 8'd0);
        chk("R6 done held", {7'd0, done}, 8'd1);

        // R9 mode 0: pci_stop_n follows pin2 pad after two edges
        pin2_pad = 1; @(negedge clk); @(negedge clk);
        chk("R9 stop follows high", {7'd0, pci_stop_n}, 8'd1);
        pin2_pad = 0; @(negedge clk);
        chk("R9 stop one edge late", {7'd0, pci_stop_n}, 8'd1);
        @(negedge clk);
        chk("R9 stop follows low", {7'd0, pci_stop_n}, 8'd0);

        // R4 pads flip at terminal tick: old levels captured
        power_cycle(5'b00011);
        run_window(1'b1);
        chk("R4 flip at terminal tick", {4'd0, fs_code}, 8'h03);
        chk("R4 mode at terminal tick", {7'd0, mode_bit}, 8'd0);

        // R7 power cycle re-samples
        @(negedge clk); pwr_good = 0; @(negedge clk);
        chk("R7 cleared", {3'd0, fs_code, done}, 8'd0);
        chk("R1 oe low in reset", {3'd0, strap_oe}, 8'd0);
        power_cycle(5'b11000);
        run_window(1'b0);
        chk("R7 resampled fs", {4'd0, fs_code}, 8'h08);
        chk("R9 mode1 pin2_oe", {7'd0, pin2_oe}, 8'd1);
        pin2_pad = 0; repeat (3) @(negedge clk);
        chk("R9 mode1 stop high", {7'd0, pci_stop_n}, 8'd1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule